// File: doc/BRIEF.md
# Windowed Stack Register File

This unit is a 32-bit register file with two banks. The global bank holds fixed, absolutely numbered registers. The local bank is a circular array of 128 entries addressed relative to a register stack pointer, and that pointer lives in global register 1. The pointer is a byte address with four bytes per register. A routine's prologue that subtracts 16 from it therefore slides the window down by four entries, and the caller's outgoing entries appear at higher local numbers in the callee.

Each cycle the unit accepts two read specifiers and one write specifier. It resolves each specifier to a physical entry. Specifier 0 is taken through a per-port indirect pointer. Accesses to unimplemented globals and to supervisor-reserved globals in user mode are flagged and neutralised. The unit also evaluates unsigned bound assertions on its two read operands. A failed assertion produces a trap request carrying a supplied trap number, which is how register-window overflow and underflow are detected. Decode, pipeline control and trap handling are outside the block.

Top module: `winreg_unit`

## Requirements
- R1: A specifier is 8 bits. Bit 7 set selects local register n = bits 6:0. Bit 7 clear selects the global register numbered by bits 6:0. Read data and its flags appear one clock after the specifiers are presented. A write is committed at the clock edge that samples it.
- R2: Local register n maps to physical local entry ((G1 >> 2) + n) mod 128, where G1 is global register 1. After G1 is lowered by 16, the entry previously reached as local 0 is reached as local 4. The mapping wraps at entry 127.
- R3: Globals 4 through 63 are unimplemented, as is an indirect access that resolves to global 0. Reading one returns zero and sets the illegal flag of that port (illegal_reg bit 0 for read A, bit 1 for read B, bit 2 for the write). A write to one is discarded and sets bit 2.
- R4: When prot_en and user_mode are both 1, globals 64 through 95 are protected. A read returns zero, a write is suppressed, and prot_viol is set with the same bit order as illegal_reg. Global 96 is never protected. With prot_en at 0 the range behaves as ordinary storage.
- R5: Global specifier 0 is replaced by the 8-bit specifier on ind_a, ind_b or ind_w, one for each of read A, read B and the write. The replacement uses the same encoding as R1.
- R6: asrt_op 01 (greater-or-equal unsigned) raises trap_req when read operand A is unsigned-less than read operand B. trap_req is high for one cycle, two clocks after the op is presented, and trap_num then equals the asrt_trapno presented with the op. Equal operands do not trap.
- R7: asrt_op 10 (less-or-equal unsigned) raises trap_req when A is unsigned-greater than B, with the same timing as R6. Codes 00 and 11 never trap. trap_num is zero whenever trap_req is low.
- R8: A read whose resolved entry equals the entry written in the same cycle returns the new write data. This holds for both banks.
- R9: In a cycle that writes global 1, local reads use the old stack pointer value. The new value governs the mapping from the next cycle on.
- R10: Synchronous reset clears every global (so the stack pointer is 0), the read outputs, all flags and trap_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_spec | input | 8 | Read port A specifier |
| rd_b_spec | input | 8 | Read port B specifier |
| ind_a | input | 8 | Indirect specifier used when read A names global 0 |
| ind_b | input | 8 | Indirect specifier used when read B names global 0 |
| wr_en | input | 1 | Write request |
| wr_spec | input | 8 | Write specifier |
| ind_w | input | 8 | Indirect specifier used when the write names global 0 |
| wr_data | input | 32 | Write data |
| user_mode | input | 1 | Core is in user mode |
| prot_en | input | 1 | Protection of the supervisor global range enabled |
| asrt_op | input | 2 | Bound assertion: 00 none, 01 greater-or-equal, 10 less-or-equal, 11 none |
| asrt_trapno | input | 8 | Trap number reported on a failed assertion |
| rd_a_data | output | 32 | Read port A data |
| rd_b_data | output | 32 | Read port B data |
| illegal_reg | output | 3 | Unimplemented-register flags: bit 0 A, bit 1 B, bit 2 write |
| prot_viol | output | 3 | Protection-violation flags: bit 0 A, bit 1 B, bit 2 write |
| trap_req | output | 1 | Assertion trap request |
| trap_num | output | 8 | Trap number accompanying trap_req |

## Verification
A corrupted stack pointer or a wrong window offset shows on the next local read as data belonging to a neighbouring entry. The bench plants distinct values at several physical entries and reads them under different pointers, so any shift or wrap error is exposed within one cycle of the read. A missed write suppression stays hidden until the protected register is read back with protection lifted, and the bench does that read explicitly. A wrong comparison direction or stale operand shows two cycles after the op, as a trap that fires or is missing at the equal, above and below boundaries.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
  localparam int unsigned SPEC_W  = 8;
  localparam int unsigned GNUM_W  = 7;
  localparam int unsigned N_GLOB  = 128;
  localparam int unsigned N_PORTS = 3;   // 0: read A, 1: read B, 2: write

  localparam logic [GNUM_W-1:0] GNUM_INDIRECT = 7'd0;
  localparam logic [GNUM_W-1:0] GNUM_RSP      = 7'd1;
  localparam logic [GNUM_W-1:0] GNUM_UNIMP_LO = 7'd4;
  localparam logic [GNUM_W-1:0] GNUM_UNIMP_HI = 7'd63;
  localparam logic [GNUM_W-1:0] GNUM_PROT_LO  = 7'd64;
  localparam logic [GNUM_W-1:0] GNUM_PROT_HI  = 7'd95;

  typedef enum logic [1:0] {
    ASRT_NONE = 2'b00,
    ASRT_GEU  = 2'b01,
    ASRT_LEU  = 2'b10,
    ASRT_RSVD = 2'b11
  } asrt_op_e;

  typedef struct packed {
    logic              is_local;
    logic [GNUM_W-1:0] gnum;
    logic              illegal;
    logic              prot;
  } reg_tgt_t;
endpackage

// File: rtl/winreg_resolve.sv
module winreg_resolve
  import winreg_pkg::*;
#(
  parameter int LOC_AW = 7
) (
  input  logic [SPEC_W-1:0] spec,
  input  logic [SPEC_W-1:0] ind_ptr,
  input  logic [LOC_AW-1:0] win_base,
  input  logic              user_mode,
  input  logic              prot_en,
  output reg_tgt_t          tgt,
  output logic [LOC_AW-1:0] loc_idx
);
  logic [SPEC_W-1:0] eff;

  always_comb begin
    eff = (!spec[SPEC_W-1] && spec[GNUM_W-1:0] == GNUM_INDIRECT) ? ind_ptr : spec;
    tgt.is_local = eff[SPEC_W-1];
    tgt.gnum     = eff[GNUM_W-1:0];
    tgt.illegal  = 1'b0;
    tgt.prot     = 1'b0;
    if (!eff[SPEC_W-1]) begin
      if (eff[GNUM_W-1:0] == GNUM_INDIRECT ||
          (eff[GNUM_W-1:0] >= GNUM_UNIMP_LO && eff[GNUM_W-1:0] <= GNUM_UNIMP_HI))
        tgt.illegal = 1'b1;
      if (prot_en && user_mode &&
          eff[GNUM_W-1:0] >= GNUM_PROT_LO && eff[GNUM_W-1:0] <= GNUM_PROT_HI)
        tgt.prot = 1'b1;
    end
    loc_idx = win_base + LOC_AW'(eff[GNUM_W-1:0]);
  end
endmodule

// File: rtl/winreg_lbank.sv
module winreg_lbank #(
  parameter  int DATA_W = 32,
  parameter  int DEPTH  = 128,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/winreg_gbank.sv
module winreg_gbank
  import winreg_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [GNUM_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [GNUM_W-1:0] raddr0,
  input  logic [GNUM_W-1:0] raddr1,
  output logic [DATA_W-1:0] rdata0,
  output logic [DATA_W-1:0] rdata1,
  output logic [DATA_W-1:0] rsp
);
  logic [DATA_W-1:0] regs [N_GLOB];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < int'(N_GLOB); i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rdata0 = regs[raddr0];
  assign rdata1 = regs[raddr1];
  assign rsp    = regs[GNUM_RSP];
endmodule

// File: rtl/winreg_acmp.sv
module winreg_acmp
  import winreg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int TRAPNO_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  asrt_op_e            op,
  input  logic [TRAPNO_W-1:0] trapno,
  input  logic [DATA_W-1:0]   opnd_a,
  input  logic [DATA_W-1:0]   opnd_b,
  output logic                trap_req,
  output logic [TRAPNO_W-1:0] trap_num
);
  logic hit;

  always_comb begin
    unique case (op)
      ASRT_GEU: hit = (opnd_a < opnd_b);
      ASRT_LEU: hit = (opnd_a > opnd_b);
      default:  hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trap_req <= 1'b0;
      trap_num <= '0;
    end else begin
      trap_req <= hit;
      trap_num <= hit ? trapno : '0;
    end
  end

  AST_TRAP_HAS_OP: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> $past(op == ASRT_GEU || op == ASRT_LEU)); // R7
  AST_TRAP_NUM_MATCH: assert property (@(posedge clk) disable iff (rst)
    trap_req |-> trap_num == $past(trapno)); // R6
endmodule

// File: rtl/winreg_unit.sv
module winreg_unit
  import winreg_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int LOC_DEPTH = 128,
  parameter int TRAPNO_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [7:0]          rd_a_spec,
  input  logic [7:0]          rd_b_spec,
  input  logic [7:0]          ind_a,
  input  logic [7:0]          ind_b,
  input  logic                wr_en,
  input  logic [7:0]          wr_spec,
  input  logic [7:0]          ind_w,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                user_mode,
  input  logic                prot_en,
  input  logic [1:0]          asrt_op,
  input  logic [TRAPNO_W-1:0] asrt_trapno,
  output logic [DATA_W-1:0]   rd_a_data,
  output logic [DATA_W-1:0]   rd_b_data,
  output logic [2:0]          illegal_reg,
  output logic [2:0]          prot_viol,
  output logic                trap_req,
  output logic [TRAPNO_W-1:0] trap_num
);
  localparam int LOC_AW = $clog2(LOC_DEPTH);
  localparam int N_RD   = 2;
  localparam int WP     = 2;

  logic [DATA_W-1:0] rsp;
  logic [LOC_AW-1:0] win_base;
  logic              unused_rsp_bits;

  assign win_base        = rsp[LOC_AW+1:2];
  assign unused_rsp_bits = ^{rsp[DATA_W-1:LOC_AW+2], rsp[1:0]};

  // ---------------- specifier resolution, one resolver per port
  logic [SPEC_W-1:0] spec_v [N_PORTS];
  logic [SPEC_W-1:0] ind_v  [N_PORTS];
  reg_tgt_t          tgt_v  [N_PORTS];
  logic [LOC_AW-1:0] lidx_v [N_PORTS];

  assign spec_v[0] = rd_a_spec;
  assign spec_v[1] = rd_b_spec;
  assign spec_v[2] = wr_spec;
  assign ind_v[0]  = ind_a;
  assign ind_v[1]  = ind_b;
  assign ind_v[2]  = ind_w;

  for (genvar p = 0; p < int'(N_PORTS); p++) begin : g_res
    winreg_resolve #(.LOC_AW(LOC_AW)) u_res (
      .spec      (spec_v[p]),
      .ind_ptr   (ind_v[p]),
      .win_base  (win_base),
      .user_mode (user_mode),
      .prot_en   (prot_en),
      .tgt       (tgt_v[p]),
      .loc_idx   (lidx_v[p])
    );
  end

  // ---------------- write gating
  logic wr_ok, g_we, l_we;
  assign wr_ok = wr_en && !tgt_v[WP].illegal && !tgt_v[WP].prot;
  assign g_we  = wr_ok && !tgt_v[WP].is_local;
  assign l_we  = wr_ok &&  tgt_v[WP].is_local;

  // ---------------- global bank
  logic [DATA_W-1:0] g_rd [N_RD];

  winreg_gbank #(.DATA_W(DATA_W)) u_gbank (
    .clk    (clk),
    .rst    (rst),
    .we     (g_we),
    .waddr  (tgt_v[WP].gnum),
    .wdata  (wr_data),
    .raddr0 (tgt_v[0].gnum),
    .raddr1 (tgt_v[1].gnum),
    .rdata0 (g_rd[0]),
    .rdata1 (g_rd[1]),
    .rsp    (rsp)
  );

  // ---------------- read ports: one local bank copy each, bypass, output select
  logic [DATA_W-1:0] rd_data [N_RD];
  logic [N_RD-1:0]   rd_ill, rd_prot;

  for (genvar p = 0; p < N_RD; p++) begin : g_rd_port
    logic [DATA_W-1:0] l_rd;
    logic              ok_q, loc_q, fwd_q, ill_q, prot_q;
    logic [DATA_W-1:0] fwd_data_q, gdat_q;
    logic              same_ent, fwd;

    winreg_lbank #(.DATA_W(DATA_W), .DEPTH(LOC_DEPTH)) u_lbank (
      .clk   (clk),
      .we    (l_we),
      .waddr (lidx_v[WP]),
      .wdata (wr_data),
      .raddr (lidx_v[p]),
      .rdata (l_rd)
    );

    assign same_ent = (tgt_v[WP].is_local == tgt_v[p].is_local) &&
                      (tgt_v[p].is_local ? (lidx_v[WP] == lidx_v[p])
                                         : (tgt_v[WP].gnum == tgt_v[p].gnum));
    assign fwd = wr_ok && same_ent;

    always_ff @(posedge clk) begin
      if (rst) begin
        ok_q       <= 1'b0;
        loc_q      <= 1'b0;
        fwd_q      <= 1'b0;
        ill_q      <= 1'b0;
        prot_q     <= 1'b0;
        fwd_data_q <= '0;
        gdat_q     <= '0;
      end else begin
        ok_q       <= !tgt_v[p].illegal && !tgt_v[p].prot;
        loc_q      <= tgt_v[p].is_local;
        fwd_q      <= fwd;
        ill_q      <= tgt_v[p].illegal;
        prot_q     <= tgt_v[p].prot;
        fwd_data_q <= wr_data;
        gdat_q     <= g_rd[p];
      end
    end

    assign rd_data[p] = !ok_q ? '0 : fwd_q ? fwd_data_q : loc_q ? l_rd : gdat_q;
    assign rd_ill[p]  = ill_q;
    assign rd_prot[p] = prot_q;
  end

  // ---------------- write-port flags
  logic wr_ill_q, wr_prot_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ill_q  <= 1'b0;
      wr_prot_q <= 1'b0;
    end else begin
      wr_ill_q  <= wr_en && tgt_v[WP].illegal;
      wr_prot_q <= wr_en && tgt_v[WP].prot;
    end
  end

  assign rd_a_data   = rd_data[0];
  assign rd_b_data   = rd_data[1];
  assign illegal_reg = {wr_ill_q, rd_ill};
  assign prot_viol   = {wr_prot_q, rd_prot};

  // ---------------- bound assertion compare
  asrt_op_e            op_q;
  logic [TRAPNO_W-1:0] trapno_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q     <= ASRT_NONE;
      trapno_q <= '0;
    end else begin
      op_q     <= asrt_op_e'(asrt_op);
      trapno_q <= asrt_trapno;
    end
  end

  winreg_acmp #(.DATA_W(DATA_W), .TRAPNO_W(TRAPNO_W)) u_acmp (
    .clk      (clk),
    .rst      (rst),
    .op       (op_q),
    .trapno   (trapno_q),
    .opnd_a   (rd_a_data),
    .opnd_b   (rd_b_data),
    .trap_req (trap_req),
    .trap_num (trap_num)
  );

  AST_UNIMP_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    illegal_reg[0] |-> rd_a_data == '0); // R3
  AST_WR_FLAG_NEEDS_WR: assert property (@(posedge clk) disable iff (rst)
    illegal_reg[2] |-> $past(wr_en)); // R3
  AST_PROT_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    prot_viol[1] |-> rd_b_data == '0); // R4
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(g_we && tgt_v[WP].gnum == GNUM_RSP) |=> $stable(rsp)); // R9
endmodule

// File: tb/winreg_unit_tb.sv
module winreg_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  rd_a_spec, rd_b_spec, ind_a, ind_b, wr_spec, ind_w;
  logic        wr_en, user_mode, prot_en;
  logic [31:0] wr_data;
  logic [1:0]  asrt_op;
  logic [7:0]  asrt_trapno;
  logic [31:0] rd_a_data, rd_b_data;
  logic [2:0]  illegal_reg, prot_viol;
  logic        trap_req;
  logic [7:0]  trap_num;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  winreg_unit dut_i (
    .clk(clk), .rst(rst),
    .rd_a_spec(rd_a_spec), .rd_b_spec(rd_b_spec), .ind_a(ind_a), .ind_b(ind_b),
    .wr_en(wr_en), .wr_spec(wr_spec), .ind_w(ind_w), .wr_data(wr_data),
    .user_mode(user_mode), .prot_en(prot_en),
    .asrt_op(asrt_op), .asrt_trapno(asrt_trapno),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
    .illegal_reg(illegal_reg), .prot_viol(prot_viol),
    .trap_req(trap_req), .trap_num(trap_num)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr_reg(input logic [7:0] spec, input logic [31:0] d);
    rd_a_spec = 8'h02; rd_b_spec = 8'h02;
    wr_en = 1'b1; wr_spec = spec; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd_regs(input logic [7:0] a, input logic [7:0] b);
    rd_a_spec = a; rd_b_spec = b;
    step();
  endtask

  task automatic t_reset();
    rd_regs(8'h01, 8'h02);
    check("R10 rsp after reset", rd_a_data, 32'h0);
    check("R10 illegal after reset", {29'b0, illegal_reg}, 32'h0);
    check("R10 prot after reset", {29'b0, prot_viol}, 32'h0);
    check("R10 trap after reset", {31'b0, trap_req}, 32'h0);
  endtask

  task automatic t_local_map();
    wr_reg(8'h01, 32'd64);
    wr_reg(8'h80, 32'h1111_0000);
    wr_reg(8'h83, 32'h3333_0000);
    rd_regs(8'h80, 8'h83);
    check("R1 local 0 at rsp 64", rd_a_data, 32'h1111_0000);
    check("R1 local 3 at rsp 64", rd_b_data, 32'h3333_0000);
    wr_reg(8'h01, 32'd48);
    rd_regs(8'h84, 8'h87);
    check("R2 old local 0 seen as local 4", rd_a_data, 32'h1111_0000);
    check("R2 old local 3 seen as local 7", rd_b_data, 32'h3333_0000);
    wr_reg(8'h01, 32'd508);
    wr_reg(8'h81, 32'hAAAA_5555);
    wr_reg(8'h01, 32'd0);
    rd_regs(8'h80, 8'h02);
    check("R2 wrap past entry 127", rd_a_data, 32'hAAAA_5555);
  endtask

  task automatic t_illegal();
    wr_reg(8'h0A, 32'h1234_5678);
    check("R3 write flag global 10", {29'b0, illegal_reg}, 32'h4);
    rd_regs(8'h0A, 8'h02);
    check("R3 read global 10 zero", rd_a_data, 32'h0);
    check("R3 read A flag", {29'b0, illegal_reg}, 32'h1);
    rd_regs(8'h02, 8'h3F);
    check("R3 read global 63 zero", rd_b_data, 32'h0);
    check("R3 read B flag", {29'b0, illegal_reg}, 32'h2);
    ind_a = 8'h00;
    rd_regs(8'h00, 8'h02);
    check("R3 indirect to global 0 flagged", {29'b0, illegal_reg}, 32'h1);
    ind_a = 8'h02;
    rd_regs(8'h02, 8'h02);
  endtask

  task automatic t_prot();
    prot_en = 1'b0; user_mode = 1'b1;
    wr_reg(8'h46, 32'h7070_7070);
    check("R4 no flag with prot_en low", {29'b0, prot_viol}, 32'h0);
    prot_en = 1'b1;
    wr_reg(8'h46, 32'hDEAD_BEEF);
    check("R4 write flag", {29'b0, prot_viol}, 32'h4);
    rd_regs(8'h46, 8'h5F);
    check("R4 protected read zero", rd_a_data, 32'h0);
    check("R4 read flags A and B", {29'b0, prot_viol}, 32'h3);
    wr_reg(8'h60, 32'h0000_0096);
    check("R4 global 96 unprotected", {29'b0, prot_viol}, 32'h0);
    rd_regs(8'h60, 8'h02);
    check("R4 global 96 readback", rd_a_data, 32'h0000_0096);
    user_mode = 1'b0;
    rd_regs(8'h46, 8'h02);
    check("R4 suppressed write left old value", rd_a_data, 32'h7070_7070);
    check("R4 supervisor no flag", {29'b0, prot_viol}, 32'h0);
    prot_en = 1'b0;
  endtask

  task automatic t_indirect();
    ind_a = 8'h46;
    rd_regs(8'h00, 8'h02);
    check("R5 indirect A to global 70", rd_a_data, 32'h7070_7070);
    ind_b = 8'h80;
    rd_regs(8'h02, 8'h00);
    check("R5 indirect B to local 0", rd_b_data, 32'hAAAA_5555);
    ind_w = 8'h03;
    wr_reg(8'h00, 32'h0000_0303);
    rd_regs(8'h03, 8'h02);
    check("R5 indirect write to global 3", rd_a_data, 32'h0000_0303);
    ind_a = 8'h02; ind_b = 8'h02; ind_w = 8'h02;
  endtask

  task automatic t_forward();
    wr_en = 1'b1; wr_spec = 8'h02; wr_data = 32'h2222_2222;
    rd_a_spec = 8'h02; rd_b_spec = 8'h85;
    step();
    check("R8 global bypass", rd_a_data, 32'h2222_2222);
    wr_spec = 8'h85; wr_data = 32'h55AA_55AA;
    step();
    check("R8 local bypass", rd_b_data, 32'h55AA_55AA);
    check("R8 earlier write committed", rd_a_data, 32'h2222_2222);
    wr_en = 1'b0;
    rd_regs(8'h02, 8'h02);
  endtask

  task automatic t_rsp_update();
    wr_reg(8'h01, 32'd64);
    wr_reg(8'h80, 32'h1616_1616);
    wr_reg(8'h01, 32'd48);
    wr_reg(8'h80, 32'h1212_1212);
    wr_reg(8'h01, 32'd64);
    wr_en = 1'b1; wr_spec = 8'h01; wr_data = 32'd48;
    rd_a_spec = 8'h80; rd_b_spec = 8'h01;
    step();
    check("R9 same-cycle read uses old rsp", rd_a_data, 32'h1616_1616);
    check("R8 rsp bypass", rd_b_data, 32'd48);
    wr_en = 1'b0;
    step();
    check("R9 next cycle uses new rsp", rd_a_data, 32'h1212_1212);
    rd_regs(8'h02, 8'h02);
  endtask

  task automatic trap_case(input string tag, input logic [1:0] op, input logic [7:0] a,
                           input logic [7:0] b, input logic [7:0] num, input logic hit);
    rd_a_spec = a; rd_b_spec = b; asrt_op = op; asrt_trapno = num;
    step();
    asrt_op = 2'b00; asrt_trapno = 8'h00;
    step();
    check({tag, " trap_req"}, {31'b0, trap_req}, {31'b0, hit});
    check({tag, " trap_num"}, {24'b0, trap_num}, hit ? {24'b0, num} : 32'h0);
    step();
    check({tag, " one-cycle pulse"}, {31'b0, trap_req}, 32'h0);
  endtask

  task automatic t_trap();
    wr_reg(8'h64, 32'h0000_0100);
    wr_reg(8'h65, 32'h0000_0200);
    trap_case("R6 geu below",   2'b01, 8'h64, 8'h65, 8'h21, 1'b1);
    trap_case("R6 geu above",   2'b01, 8'h65, 8'h64, 8'h21, 1'b0);
    trap_case("R6 geu equal",   2'b01, 8'h64, 8'h64, 8'h21, 1'b0);
    trap_case("R7 leu above",   2'b10, 8'h65, 8'h64, 8'h22, 1'b1);
    trap_case("R7 leu below",   2'b10, 8'h64, 8'h65, 8'h22, 1'b0);
    trap_case("R7 leu equal",   2'b10, 8'h64, 8'h64, 8'h22, 1'b0);
    trap_case("R7 code 11",     2'b11, 8'h64, 8'h65, 8'h23, 1'b0);
    rd_regs(8'h02, 8'h02);
  endtask

  initial begin
    rst = 1'b1;
    rd_a_spec = 8'h02; rd_b_spec = 8'h02;
    ind_a = 8'h02; ind_b = 8'h02; ind_w = 8'h02;
    wr_en = 1'b0; wr_spec = 8'h02; wr_data = '0;
    user_mode = 1'b0; prot_en = 1'b0;
    asrt_op = 2'b00; asrt_trapno = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_local_map();
    t_illegal();
    t_prot();
    t_indirect();
    t_forward();
    t_rsp_update();
    t_trap();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule